// File: doc/BRIEF.md
# Serial Audio Transmit Channel with Sample Queue

This block turns a stream of 32-bit words written by a host into a two-channel serial audio bit stream. Each accepted word waits in an eight-entry queue. On every pulse of an externally generated bit-clock enable, the channel moves one bit onto the serial data line, lined up with a word-select signal that marks the left and right halves of each frame. The block can generate word-select itself, with a programmable half period, or follow a word-select driven from outside.

A 16-bit control register holds the frame settings:

| Bits | Field |
|------|-------|
| [8:0] | half period minus one |
| [10:9] | sample width code, where code c means c+1 bytes |
| [11] | mono |
| [12] | follow external word-select |
| [13] | mute |
| [14] | stop |
| [15] | channel clear |

The queue fill level is always visible. Three request lines (one interrupt and two DMA requests) each compare that level against their own threshold, and each has its own enable. A sticky flag records any word that fell due while the queue was empty.

Top module: `audio_tx_channel`

## Requirements
- R1: After reset the control register reads 0x321F. That value means half period field 31, width code 1 (two bytes), stereo, external word-select, mute set, stop clear and clear bit clear. A write with `ctrl_we` loads `ctrl_wdata` into the register.
- R2: The queue holds up to 8 words and `fill_level` reports how many it holds. A write to a full queue is dropped.
- R3: In internal word-select mode (bit 12 = 0), `ws_out` starts low and toggles after every (half field + 1) bit-clock enable pulses. It changes on no other cycle.
- R4: In external mode (bit 12 = 1), `ws_out` takes the value of `ws_in` sampled on each bit-clock enable pulse.
- R5: A sample is the low 8*(code+1) bits of the written word, and any higher bits are ignored. It is sent MSB first, starting on the bit clock after the word-select edge. Positions after its last bit in the same half are sent as 0. Left data goes out while `ws_out` is low.
- R6: In stereo, a left sample is taken from the queue at each falling word-select edge and a right sample at each rising edge. A rising edge that does not follow a taken left sample sends zeros and leaves the queue untouched.
- R7: In mono (bit 11 = 1), one word is taken per frame at the falling edge, and the same sample is sent in both halves.
- R8: While mute is set, `sd_out` is 0, but samples are still taken from the queue at their normal points.
- R9: While stop is set, writes are ignored, no sample is taken from the queue and `sd_out` is 0.
- R10: While the clear bit is set, the queue, the serializer, the word-select generator and the underrun flag are held cleared asynchronously. This gives `fill_level` 0, `underrun` 0 and `ws_out` 0.
- R11: Each request line (`irq`, `dreq_a`, `dreq_b`) is 1 exactly when its enable is 1 and `fill_level` is at or below its 4-bit threshold.
- R12: When a sample falls due and the queue is empty (a falling edge, or a rising edge after a taken left sample in stereo), zeros are sent and `underrun` becomes 1. It stays 1 until a channel clear.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | system clock |
| rst_n | input | 1 | asynchronous active-low reset |
| ctrl_we | input | 1 | load control register |
| ctrl_wdata | input | 16 | control register write value |
| wr_en | input | 1 | push one word into the queue |
| wr_data | input | 32 | word to push, sample in low bits |
| bclk_en | input | 1 | one-cycle pulse per bit clock |
| ws_in | input | 1 | external word-select |
| irq_en | input | 1 | interrupt request enable |
| irq_thr | input | 4 | interrupt fill-level threshold |
| dreq_a_en | input | 1 | first DMA request enable |
| dreq_a_thr | input | 4 | first DMA request threshold |
| dreq_b_en | input | 1 | second DMA request enable |
| dreq_b_thr | input | 4 | second DMA request threshold |
| ctrl_rdata | output | 16 | control register contents |
| ws_out | output | 1 | word-select, low for left |
| sd_out | output | 1 | serial data |
| fill_level | output | 4 | words held in the queue |
| underrun | output | 1 | sticky empty-queue flag |
| irq | output | 1 | interrupt request |
| dreq_a | output | 1 | first DMA request |
| dreq_b | output | 1 | second DMA request |

## Verification
Stereo 32-bit frames with a 64-clock frame are run until the queue drains. This shows left/right ordering, MSB-first alignment, the discarded first right half and the underrun at the first left edge that finds the queue empty. Mono 8-bit samples in a 32-clock frame are sent with junk in the upper word bits, which separates sample repetition from stereo alternation and shows the zero padding. Mute and stop are each run over full frames and then judged by the fill level: mute must still drain the queue and stop must not. The external word-select run uses 20-clock halves that match no internal setting, so a `ws_out` that follows the internal counter cannot be mistaken for one that follows the input.

// File: rtl/audtx_pkg.sv
package audtx_pkg;

    localparam int SAMPLE_W = 32;
    localparam int CTRL_W   = 16;
    localparam int HALF_W   = 9;

    typedef struct packed {
        logic              clear;
        logic              stop;
        logic              mute;
        logic              ws_slave;
        logic              mono;
        logic [1:0]        width;
        logic [HALF_W-1:0] half;
    } ctrl_t;

    localparam logic [CTRL_W-1:0] CTRL_RESET = 16'h321F;

    // Move a right-aligned sample of (code+1) bytes to the top of the word.
    function automatic logic [SAMPLE_W-1:0] left_align(input logic [SAMPLE_W-1:0] w,
                                                       input logic [1:0] code);
        int sh;
        sh = SAMPLE_W - 8 * (int'(code) + 1);
        return w << sh;
    endfunction

endpackage

// File: rtl/audtx_fifo.sv
module audtx_fifo #(
    parameter int DEPTH = 8,
    parameter int W     = 32,
    localparam int PTR_W = $clog2(DEPTH),
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             push,
    input  logic [W-1:0]     push_data,
    input  logic             pop,
    output logic [W-1:0]     head,
    output logic [LVL_W-1:0] level
);
    typedef struct packed {
        logic [PTR_W-1:0] wp;
        logic [PTR_W-1:0] rp;
        logic [LVL_W-1:0] lvl;
    } fifo_st_t;

    fifo_st_t st_d, st_q;
    logic [W-1:0] mem [DEPTH];
    logic do_push, do_pop;

    always_comb begin
        st_d    = st_q;
        do_push = push && (st_q.lvl < LVL_W'(DEPTH));
        do_pop  = pop && (st_q.lvl != '0);
        if (do_push) st_d.wp = (st_q.wp == PTR_W'(DEPTH - 1)) ? '0 : st_q.wp + 1'b1;
        if (do_pop)  st_d.rp = (st_q.rp == PTR_W'(DEPTH - 1)) ? '0 : st_q.rp + 1'b1;
        if (do_push && !do_pop)      st_d.lvl = st_q.lvl + 1'b1;
        else if (do_pop && !do_push) st_d.lvl = st_q.lvl - 1'b1;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    always_ff @(posedge clk) begin
        if (do_push) mem[st_q.wp] <= push_data;
    end

    assign head  = mem[st_q.rp];
    assign level = st_q.lvl;
endmodule

// File: rtl/audtx_frame.sv
module audtx_frame #(
    parameter int HALF_W = 9
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              tick,
    input  logic              slave,
    input  logic [HALF_W-1:0] half,
    input  logic              ws_in,
    output logic              ws_o,
    output logic              edge_o,
    output logic              side_o
);
    typedef struct packed {
        logic              ws;
        logic [HALF_W-1:0] pos;
    } frame_st_t;

    frame_st_t st_d, st_q;

    always_comb begin
        st_d   = st_q;
        edge_o = 1'b0;
        if (tick) begin
            if (slave) begin
                st_d.pos = '0;
                if (ws_in != st_q.ws) begin
                    edge_o  = 1'b1;
                    st_d.ws = ws_in;
                end
            end else if (st_q.pos >= half) begin
                edge_o   = 1'b1;
                st_d.ws  = ~st_q.ws;
                st_d.pos = '0;
            end else begin
                st_d.pos = st_q.pos + 1'b1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign ws_o   = st_q.ws;
    assign side_o = st_d.ws;
endmodule

// File: rtl/audtx_serializer.sv
module audtx_serializer
    import audtx_pkg::*;
(
    input  logic                clk,
    input  logic                rst_n,
    input  logic                tick,
    input  logic                edge_i,
    input  logic                side_i,
    input  logic                mono,
    input  logic                mute,
    input  logic                stop,
    input  logic [1:0]          width,
    input  logic                empty,
    input  logic [SAMPLE_W-1:0] head,
    output logic                pop,
    output logic                sd,
    output logic                underrun
);
    typedef struct packed {
        logic [SAMPLE_W-1:0] sh;
        logic [SAMPLE_W-1:0] hold;
        logic                left_taken;
        logic                sd;
        logic                underrun;
    } ser_st_t;

    ser_st_t st_d, st_q;
    logic [SAMPLE_W-1:0] load_word;
    logic                quiet;

    always_comb begin
        st_d      = st_q;
        pop       = 1'b0;
        load_word = '0;
        quiet     = mute || stop;
        if (tick) begin
            st_d.sd = quiet ? 1'b0 : st_q.sh[SAMPLE_W-1];
            if (edge_i) begin
                if (!side_i) begin
                    st_d.left_taken = 1'b0;
                    if (!stop) begin
                        if (!empty) begin
                            pop             = 1'b1;
                            load_word       = left_align(head, width);
                            st_d.hold       = load_word;
                            st_d.left_taken = 1'b1;
                        end else begin
                            st_d.underrun = 1'b1;
                        end
                    end
                end else begin
                    st_d.left_taken = 1'b0;
                    if (!stop && st_q.left_taken) begin
                        if (mono) begin
                            load_word = st_q.hold;
                        end else if (!empty) begin
                            pop       = 1'b1;
                            load_word = left_align(head, width);
                        end else begin
                            st_d.underrun = 1'b1;
                        end
                    end
                end
                st_d.sh = quiet ? '0 : load_word;
            end else begin
                st_d.sh = st_q.sh << 1;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) st_q <= '0;
        else        st_q <= st_d;
    end

    assign sd       = st_q.sd;
    assign underrun = st_q.underrun;
endmodule

// File: rtl/audtx_levels.sv
module audtx_levels #(
    parameter int N     = 3,
    parameter int LVL_W = 4
) (
    input  logic [LVL_W-1:0]   level,
    input  logic [N-1:0]       en,
    input  logic [N*LVL_W-1:0] thr,
    output logic [N-1:0]       req
);
    for (genvar i = 0; i < N; i++) begin : g_req
        assign req[i] = en[i] && (level <= thr[i*LVL_W +: LVL_W]);
    end
endmodule

// File: rtl/audio_tx_channel.sv
module audio_tx_channel
    import audtx_pkg::*;
#(
    parameter int DEPTH = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic                ctrl_we,
    input  logic [CTRL_W-1:0]   ctrl_wdata,
    input  logic                wr_en,
    input  logic [SAMPLE_W-1:0] wr_data,
    input  logic                bclk_en,
    input  logic                ws_in,
    input  logic                irq_en,
    input  logic [LVL_W-1:0]    irq_thr,
    input  logic                dreq_a_en,
    input  logic [LVL_W-1:0]    dreq_a_thr,
    input  logic                dreq_b_en,
    input  logic [LVL_W-1:0]    dreq_b_thr,
    output logic [CTRL_W-1:0]   ctrl_rdata,
    output logic                ws_out,
    output logic                sd_out,
    output logic [LVL_W-1:0]    fill_level,
    output logic                underrun,
    output logic                irq,
    output logic                dreq_a,
    output logic                dreq_b
);
    ctrl_t ctrl_d, ctrl_q;
    logic  chan_rst_n;
    logic  edge_w, side_w, pop_w;
    logic  [SAMPLE_W-1:0] head_w;
    logic  [2:0] req_w;

    always_comb begin
        ctrl_d = ctrl_q;
        if (ctrl_we) ctrl_d = ctrl_t'(ctrl_wdata);
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) ctrl_q <= ctrl_t'(CTRL_RESET);
        else        ctrl_q <= ctrl_d;
    end

    assign chan_rst_n = rst_n && !ctrl_q.clear;

    audtx_fifo #(.DEPTH(DEPTH), .W(SAMPLE_W)) i_fifo (
        .clk(clk), .rst_n(chan_rst_n),
        .push(wr_en && !ctrl_q.stop), .push_data(wr_data),
        .pop(pop_w), .head(head_w), .level(fill_level)
    );

    audtx_frame #(.HALF_W(HALF_W)) i_frame (
        .clk(clk), .rst_n(chan_rst_n), .tick(bclk_en),
        .slave(ctrl_q.ws_slave), .half(ctrl_q.half), .ws_in(ws_in),
        .ws_o(ws_out), .edge_o(edge_w), .side_o(side_w)
    );

    audtx_serializer i_ser (
        .clk(clk), .rst_n(chan_rst_n), .tick(bclk_en),
        .edge_i(edge_w), .side_i(side_w), .mono(ctrl_q.mono),
        .mute(ctrl_q.mute), .stop(ctrl_q.stop), .width(ctrl_q.width),
        .empty(fill_level == '0), .head(head_w),
        .pop(pop_w), .sd(sd_out), .underrun(underrun)
    );

    audtx_levels #(.N(3), .LVL_W(LVL_W)) i_levels (
        .level(fill_level),
        .en({dreq_b_en, dreq_a_en, irq_en}),
        .thr({dreq_b_thr, dreq_a_thr, irq_thr}),
        .req(req_w)
    );

    assign irq        = req_w[0];
    assign dreq_a     = req_w[1];
    assign dreq_b     = req_w[2];
    assign ctrl_rdata = ctrl_q;
endmodule

// File: rtl/audtx_checker.sv
module audtx_checker #(
    parameter int DEPTH = 8,
    localparam int LVL_W = $clog2(DEPTH + 1)
) (
    input logic             clk,
    input logic             rst_n,
    input logic             bclk_en,
    input logic [15:0]      ctrl_rdata,
    input logic             ws_out,
    input logic             sd_out,
    input logic [LVL_W-1:0] fill_level,
    input logic             underrun,
    input logic             irq_en,
    input logic             irq
);
    // R2
    level_bound_chk: assert property (@(posedge clk) disable iff (!rst_n)
        fill_level <= LVL_W'(DEPTH));

    // R3
    ws_on_tick_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (!$past(bclk_en) && !$past(ctrl_rdata[15]) && !ctrl_rdata[15]) |-> $stable(ws_out));

    // R8
    quiet_line_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(bclk_en) && ($past(ctrl_rdata[13]) || $past(ctrl_rdata[14]))) |-> !sd_out);

    // R9
    stop_no_fill_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (ctrl_rdata[14] && !ctrl_rdata[15]) |=> fill_level <= $past(fill_level));

    // R10
    clear_held_chk: assert property (@(posedge clk) disable iff (!rst_n)
        ctrl_rdata[15] |-> (fill_level == '0 && !underrun && !ws_out));

    // R11
    irq_gate_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !irq_en |-> !irq);

    // R12
    underrun_sticky_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (underrun && !ctrl_rdata[15]) |=> (underrun || ctrl_rdata[15]));
endmodule

bind audio_tx_channel audtx_checker #(.DEPTH(DEPTH)) i_chk (
    .clk(clk), .rst_n(rst_n), .bclk_en(bclk_en), .ctrl_rdata(ctrl_rdata),
    .ws_out(ws_out), .sd_out(sd_out), .fill_level(fill_level),
    .underrun(underrun), .irq_en(irq_en), .irq(irq)
);

// File: tb/test_audio_tx_channel.sv
module test_audio_tx_channel;
    logic        clk = 1'b0;
    logic        rst_n = 1'b0;
    logic        ctrl_we = 1'b0;
    logic [15:0] ctrl_wdata = '0;
    logic        wr_en = 1'b0;
    logic [31:0] wr_data = '0;
    logic        bclk_en = 1'b0;
    logic        ws_in = 1'b0;
    logic        irq_en = 1'b0, dreq_a_en = 1'b0, dreq_b_en = 1'b0;
    logic [3:0]  irq_thr = '0, dreq_a_thr = '0, dreq_b_thr = '0;
    logic [15:0] ctrl_rdata;
    logic        ws_out, sd_out, underrun, irq, dreq_a, dreq_b;
    logic [3:0]  fill_level;

    int n_chk = 0;
    int n_fail = 0;
    bit done = 0;

    logic cap_ws [512];
    logic cap_sd [512];
    logic cap_drv [512];
    int   cap_n;
    logic [31:0] got_w [16];
    logic        got_side [16];
    int          got_at [16];
    int          got_n;

    always #5 clk = ~clk;

    audio_tx_channel i_audio_tx_channel (
        .clk(clk), .rst_n(rst_n), .ctrl_we(ctrl_we), .ctrl_wdata(ctrl_wdata),
        .wr_en(wr_en), .wr_data(wr_data), .bclk_en(bclk_en), .ws_in(ws_in),
        .irq_en(irq_en), .irq_thr(irq_thr), .dreq_a_en(dreq_a_en), .dreq_a_thr(dreq_a_thr),
        .dreq_b_en(dreq_b_en), .dreq_b_thr(dreq_b_thr), .ctrl_rdata(ctrl_rdata),
        .ws_out(ws_out), .sd_out(sd_out), .fill_level(fill_level), .underrun(underrun),
        .irq(irq), .dreq_a(dreq_a), .dreq_b(dreq_b)
    );

    function automatic logic [15:0] mk(input int half, input int code, input bit mono,
                                       input bit slave, input bit mute, input bit stop);
        return {1'b0, stop, mute, slave, mono, 2'(code), 9'(half)};
    endfunction

    task automatic chk(input string req, input string what,
                       input logic [31:0] act, input logic [31:0] exp);
        n_chk++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s %s: actual %h expected %h", req, what, act, exp);
        end
    endtask

    task automatic wctrl(input logic [15:0] v);
        @(negedge clk); ctrl_we = 1'b1; ctrl_wdata = v;
        @(negedge clk); ctrl_we = 1'b0;
    endtask

    task automatic chan_clear(input logic [15:0] v);
        wctrl(v | 16'h8000);
        wctrl(v);
        cap_n = 0;
    endtask

    task automatic push(input logic [31:0] d);
        @(negedge clk); wr_en = 1'b1; wr_data = d;
        @(negedge clk); wr_en = 1'b0;
    endtask

    task automatic ticks(input int n, input bit use_ws, input int seg);
        for (int k = 0; k < n; k++) begin
            @(negedge clk);
            bclk_en = 1'b1;
            if (use_ws) ws_in = ((k / seg) % 2 == 0);
            @(negedge clk);
            bclk_en = 1'b0;
            cap_ws[cap_n] = ws_out;
            cap_sd[cap_n] = sd_out;
            cap_drv[cap_n] = ws_in;
            cap_n++;
            @(negedge clk);
            @(negedge clk);
        end
    endtask

    task automatic decode(input int nb);
        got_n = 0;
        for (int i = 1; i < cap_n; i++) begin
            if (cap_ws[i] != cap_ws[i-1] && i + nb < cap_n && got_n < 16) begin
                logic [31:0] w;
                w = '0;
                for (int j = 1; j <= nb; j++) w = {w[30:0], cap_sd[i+j]};
                got_w[got_n] = w;
                got_side[got_n] = cap_ws[i];
                got_at[got_n] = i;
                got_n++;
            end
        end
    endtask

    task automatic t_reset();
        chk("R1", "ctrl reset value", 32'(ctrl_rdata), 32'h321F);
        chk("R2", "level after reset", 32'(fill_level), 0);
        chk("R3", "ws low after reset", 32'(ws_out), 0);
        chk("R11", "requests off when disabled", {29'd0, irq, dreq_a, dreq_b}, 0);
        chk("R12", "underrun clear after reset", 32'(underrun), 0);
    endtask

    task automatic t_fill();
        irq_en = 1'b1; irq_thr = 4'd4;
        dreq_a_en = 1'b1; dreq_a_thr = 4'd8;
        dreq_b_en = 1'b0; dreq_b_thr = 4'd15;
        for (int k = 0; k < 3; k++) push(32'h100 + k);
        @(negedge clk);
        chk("R2", "level after 3 writes", 32'(fill_level), 3);
        chk("R11", "irq at level 3 thr 4", 32'(irq), 1);
        for (int k = 0; k < 7; k++) push(32'h200 + k);
        @(negedge clk);
        chk("R2", "level saturates at 8", 32'(fill_level), 8);
        chk("R11", "irq off at level 8 thr 4", 32'(irq), 0);
        chk("R11", "dreq_a at level 8 thr 8", 32'(dreq_a), 1);
        chk("R11", "dreq_b disabled", 32'(dreq_b), 0);
        wctrl(16'h321F | 16'h8000);
        chk("R10", "level while clear held", 32'(fill_level), 0);
        chk("R1", "ctrl write loads register", 32'(ctrl_rdata), 32'hB21F);
        wctrl(16'h321F);
        irq_en = 1'b0; dreq_a_en = 1'b0;
    endtask

    task automatic t_stereo32();
        chan_clear(mk(31, 3, 0, 0, 0, 0));
        push(32'hDEADBEEF); push(32'h01234567); push(32'h80000001); push(32'h7FFF0000);
        ticks(230, 0, 1);
        decode(32);
        chk("R6", "decoded word count", 32'(got_n), 6);
        if (got_n >= 6) begin
            chk("R3", "first edge position", 32'(got_at[0]), 31);
            for (int k = 1; k < 6; k++)
                chk("R3", "half period spacing", 32'(got_at[k] - got_at[k-1]), 32);
            chk("R6", "first right half is empty", got_w[0], 0);
            chk("R5", "left word on ws low", {31'd0, got_side[1]}, 0);
            chk("R5", "left 1", got_w[1], 32'hDEADBEEF);
            chk("R6", "right 1", got_w[2], 32'h01234567);
            chk("R5", "left 2", got_w[3], 32'h80000001);
            chk("R6", "right 2", got_w[4], 32'h7FFF0000);
            chk("R12", "zeros when empty", got_w[5], 0);
        end
        chk("R12", "underrun set", 32'(underrun), 1);
        ticks(5, 0, 1);
        chk("R12", "underrun sticky", 32'(underrun), 1);
    endtask

    task automatic t_mono8();
        chan_clear(mk(15, 0, 1, 0, 0, 0));
        chk("R10", "clear drops underrun", 32'(underrun), 0);
        push(32'hABCD1234); push(32'hFFFF5A5A);
        ticks(100, 0, 1);
        decode(16);
        chk("R7", "decoded word count", 32'(got_n), 5);
        if (got_n >= 5) begin
            chk("R7", "left sample 1 padded", got_w[1], 32'h3400);
            chk("R7", "right repeats sample 1", got_w[2], 32'h3400);
            chk("R5", "left sample 2 high bits ignored", got_w[3], 32'h5A00);
            chk("R7", "right repeats sample 2", got_w[4], 32'h5A00);
        end
        chk("R12", "underrun at next left edge", 32'(underrun), 1);
    endtask

    task automatic t_mute();
        int ones;
        chan_clear(mk(15, 1, 0, 0, 1, 0));
        for (int k = 0; k < 4; k++) push(32'hFFFF_FFFF);
        ticks(70, 0, 1);
        ones = 0;
        for (int i = 0; i < cap_n; i++) if (cap_sd[i]) ones++;
        chk("R8", "muted line all zero", 32'(ones), 0);
        chk("R8", "mute still drains three words", 32'(fill_level), 1);
        chk("R8", "no underrun while muted", 32'(underrun), 0);
    endtask

    task automatic t_stop();
        int ones;
        chan_clear(mk(15, 1, 0, 0, 0, 1));
        push(32'h1); push(32'h2);
        @(negedge clk);
        chk("R9", "writes ignored in stop", 32'(fill_level), 0);
        wctrl(mk(15, 1, 0, 0, 0, 0));
        push(32'hFFFF); push(32'hFFFF);
        wctrl(mk(15, 1, 0, 0, 0, 1));
        cap_n = 0;
        ticks(70, 0, 1);
        ones = 0;
        for (int i = 0; i < cap_n; i++) if (cap_sd[i]) ones++;
        chk("R9", "stopped line all zero", 32'(ones), 0);
        chk("R9", "no words taken in stop", 32'(fill_level), 2);
        chk("R9", "no underrun in stop", 32'(underrun), 0);
    endtask

    task automatic t_slave();
        int bad;
        chan_clear(mk(31, 1, 0, 1, 0, 0));
        push(32'h0000C3A5); push(32'h00000F0F);
        ticks(70, 1, 20);
        bad = 0;
        for (int i = 0; i < cap_n; i++) if (cap_ws[i] !== cap_drv[i]) bad++;
        chk("R4", "ws follows input", 32'(bad), 0);
        decode(16);
        chk("R4", "decoded word count", 32'(got_n), 2);
        if (got_n >= 2) begin
            chk("R4", "first edge at input change", 32'(got_at[0]), 20);
            chk("R5", "left 16-bit sample", got_w[0], 32'hC3A5);
            chk("R6", "right 16-bit sample", got_w[1], 32'h0F0F);
        end
        chk("R12", "underrun at third edge", 32'(underrun), 1);
    endtask

    initial begin
        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        t_reset();
        t_fill();
        t_stereo32();
        t_mono8();
        t_mute();
        t_stop();
        t_slave();
        if (!done) begin
            done = 1;
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end

    initial begin
        repeat (150000) @(posedge clk);
        if (!done) begin
            done = 1;
            n_chk++;
            n_fail++;
            $display("FAIL watchdog: actual timeout expected completion");
            $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
            $finish;
        end
    end
endmodule